// File: doc/BRIEF.md
# Saturating Halfword Multiply-Accumulate Engine

This engine carries out one multiply-accumulate step each time it is started. It holds two address pointers. At each step it reads one signed 16-bit operand through each pointer, using a single shared read port. After each read, the pointer used is advanced by two bytes. The two operands are multiplied into a signed 32-bit product, and the product is added into a 64-bit accumulator held as an upper word and a lower word.

A mode input chooses between two ways of accumulating. With the mode clear, the product is sign-extended and added across the full 64 bits. With the mode set, only the lower word takes part in the addition. On signed overflow, the lower word is clamped to the nearest 32-bit signed limit, and bit 0 of the upper word is set as a sticky overflow flag. The surrounding logic loads the pointers and the accumulator while the engine is idle, pulses a start input, and waits for a one-cycle completion pulse.

Top module: `smac_unit`

## Requirements
- R1: Reset is synchronous and active high. During reset, both pointers and both accumulator words are cleared, and `busy`, `done` and `rd_req` are low.
- R2: After a start, the engine makes exactly two reads, one at a time. The first read uses `ptr_a` and the second uses `ptr_b`. `rd_req` stays high with a steady `rd_addr` until `rd_ack` is seen. The 16-bit `rd_data` is taken in the cycle in which `rd_ack` is high.
- R3: Each pointer advances by 2, wrapping modulo 2^ADDR_W, on the clock edge that accepts its read.
- R4: The product is the signed 32-bit product of the two operands, each read as a two's-complement 16-bit value.
- R5: With the mode clear, the 64-bit value {acc_hi, acc_lo} grows by the product sign-extended to 64 bits.
- R6: With the mode set and no overflow, acc_lo becomes acc_lo plus the product, and acc_hi is left unchanged.
- R7: With the mode set, overflow means the exact sum of acc_lo and the product, both taken as signed values, lies outside the 32-bit signed range. On overflow, acc_lo becomes 0x7FFFFFFF for a non-negative product and 0x80000000 for a negative product.
- R8: On overflow with the mode set, bit 0 of acc_hi becomes 1, and the other bits of acc_hi are kept. While the mode is set, that bit stays 1 through later steps until the accumulator is loaded.
- R9: `done` is high for exactly one cycle. In that cycle the accumulator and both pointers already show their new values and `busy` is low. `busy` is high from the cycle after an accepted start until then.
- R10: The mode value is taken when the start is accepted. `ptr_ld` loads both pointers and `acc_ld` loads both accumulator words, but only while the engine is idle. While `busy` is high, `start`, `ptr_ld`, `acc_ld` and changes to the mode have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one step (accepted when idle) |
| sat_mode | input | 1 | 1 = saturating lower-word mode, 0 = full 64-bit mode |
| ptr_ld | input | 1 | Load both pointers (idle only) |
| ptr_a_in | input | ADDR_W | Load value for the first pointer |
| ptr_b_in | input | ADDR_W | Load value for the second pointer |
| acc_ld | input | 1 | Load both accumulator words (idle only) |
| acc_hi_in | input | 32 | Load value for the upper word |
| acc_lo_in | input | 32 | Load value for the lower word |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | ADDR_W | Read address |
| rd_ack | input | 1 | Read data valid |
| rd_data | input | 16 | Read data |
| ptr_a | output | ADDR_W | First pointer |
| ptr_b | output | ADDR_W | Second pointer |
| acc_hi | output | 32 | Upper accumulator word |
| acc_lo | output | 32 | Lower accumulator word |
| busy | output | 1 | Step in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
In saturating mode, two things land on the same clock edge: the clamp of the lower word and the setting of the sticky bit in the upper word. A fault in either one alone would leave the other looking correct.

The sweep provokes both together. It preloads the lower word next to each signed limit, with bit 0 of the upper word both clear and set, and multiplies every pairing of extreme and ordinary operands.

Both words are then judged at the `done` pulse against an exact signed sum formed in the bench, together with a follow-up step that must keep the sticky bit.

// File: rtl/smac_pkg.sv
package smac_pkg;

    localparam int OPND_W = 16;
    localparam int WORD_W = 32;

    typedef logic [OPND_W-1:0] opnd_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [WORD_W:0]   wide_t;

    typedef struct packed {
        word_t hi;
        word_t lo;
    } acc_t;

    typedef struct packed {
        opnd_t a;
        opnd_t b;
        logic  sat;
    } job_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_EXEC  = 2'd2
    } fsm_e;

    localparam word_t SAT_POS = {1'b0, {(WORD_W-1){1'b1}}};
    localparam word_t SAT_NEG = {1'b1, {(WORD_W-1){1'b0}}};

    function automatic word_t sext_opnd(opnd_t v);
        return {{(WORD_W-OPND_W){v[OPND_W-1]}}, v};
    endfunction

    function automatic word_t prod_of(opnd_t a, opnd_t b);
        logic signed [WORD_W-1:0] ea;
        logic signed [WORD_W-1:0] eb;
        ea = sext_opnd(a);
        eb = sext_opnd(b);
        return word_t'(ea * eb);
    endfunction

    function automatic wide_t wide_add(word_t x, word_t y);
        return {1'b0, x} + {1'b0, y};
    endfunction

    function automatic logic add_ovf(word_t p, word_t l, word_t s);
        return (p[WORD_W-1] == l[WORD_W-1]) && (s[WORD_W-1] != p[WORD_W-1]);
    endfunction

    function automatic word_t clamp_of(word_t p);
        return p[WORD_W-1] ? SAT_NEG : SAT_POS;
    endfunction

    function automatic word_t hi_with_carry(word_t hi, word_t p, logic c);
        return hi + {WORD_W{p[WORD_W-1]}} + word_t'(c);
    endfunction

endpackage

// File: rtl/smac_fetch.sv
module smac_fetch
    import smac_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PTR_STEP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sat_mode,
    input  logic              ptr_ld,
    input  logic [ADDR_W-1:0] ptr_a_in,
    input  logic [ADDR_W-1:0] ptr_b_in,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  opnd_t             rd_data,
    output logic [ADDR_W-1:0] ptr_a,
    output logic [ADDR_W-1:0] ptr_b,
    output logic              busy,
    output logic              job_vld,
    output job_t              job
);

    localparam int                NUM_PTR = 2;
    localparam logic [ADDR_W-1:0] STEP_V  = ADDR_W'(PTR_STEP);

    fsm_e              state_q;
    logic              slot_q;
    logic              mode_q;
    logic [ADDR_W-1:0] ptr_q   [NUM_PTR];
    logic [ADDR_W-1:0] ld_val  [NUM_PTR];
    opnd_t             opnd_q  [NUM_PTR];
    logic              idle;
    logic              take;

    assign idle      = (state_q == ST_IDLE);
    assign take      = (state_q == ST_FETCH) && rd_ack;
    assign ld_val[0] = ptr_a_in;
    assign ld_val[1] = ptr_b_in;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            slot_q  <= 1'b0;
            mode_q  <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_FETCH;
                        slot_q  <= 1'b0;
                        mode_q  <= sat_mode;
                    end
                end
                ST_FETCH: begin
                    if (rd_ack) begin
                        if (slot_q) begin
                            state_q <= ST_EXEC;
                        end
                        slot_q <= ~slot_q;
                    end
                end
                ST_EXEC: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    for (genvar gi = 0; gi < NUM_PTR; gi++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst) begin
                ptr_q[gi]  <= '0;
                opnd_q[gi] <= '0;
            end else if (idle && ptr_ld) begin
                ptr_q[gi] <= ld_val[gi];
            end else if (take && (slot_q == 1'(gi))) begin
                opnd_q[gi] <= rd_data;
                ptr_q[gi]  <= ptr_q[gi] + STEP_V;
            end
        end
    end

    assign rd_req  = (state_q == ST_FETCH);
    assign rd_addr = ptr_q[slot_q];
    assign ptr_a   = ptr_q[0];
    assign ptr_b   = ptr_q[1];
    assign busy    = !idle;
    assign job_vld = (state_q == ST_EXEC);
    assign job     = '{a: opnd_q[0], b: opnd_q[1], sat: mode_q};

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr))); // R2

    AST_PTR_A_STEP: assert property (@(posedge clk) disable iff (rst)
        (take && !slot_q) |=> (ptr_a == $past(ptr_a) + STEP_V)); // R3

    AST_PTR_B_STEP: assert property (@(posedge clk) disable iff (rst)
        (take && slot_q) |=> (ptr_b == $past(ptr_b) + STEP_V)); // R3

    AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
        (busy && !job_vld) |=> $stable(job.sat)); // R10

endmodule

// File: rtl/smac_acc.sv
module smac_acc
    import smac_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic job_vld,
    input  job_t job,
    input  logic ld,
    input  acc_t ld_val,
    output acc_t acc
);

    acc_t  acc_q;
    acc_t  acc_nx;
    word_t prod;
    wide_t lo_wide;
    word_t lo_sum;
    logic  lo_carry;
    logic  ovf;

    assign prod     = prod_of(job.a, job.b);
    assign lo_wide  = wide_add(acc_q.lo, prod);
    assign lo_sum   = lo_wide[WORD_W-1:0];
    assign lo_carry = lo_wide[WORD_W];
    assign ovf      = add_ovf(prod, acc_q.lo, lo_sum);

    always_comb begin
        acc_nx = acc_q;
        if (job.sat) begin
            if (ovf) begin
                acc_nx.hi = acc_q.hi | word_t'(1);
                acc_nx.lo = clamp_of(prod);
            end else begin
                acc_nx.lo = lo_sum;
            end
        end else begin
            acc_nx.hi = hi_with_carry(acc_q.hi, prod, lo_carry);
            acc_nx.lo = lo_sum;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q <= '0;
        end else if (job_vld) begin
            acc_q <= acc_nx;
        end else if (ld) begin
            acc_q <= ld_val;
        end
    end

    assign acc = acc_q;

    AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (job_vld && job.sat && ovf) |=> (acc_q.lo == SAT_POS || acc_q.lo == SAT_NEG)); // R7

    AST_STICKY_KEEP: assert property (@(posedge clk) disable iff (rst)
        (job_vld && job.sat && acc_q.hi[0]) |=> acc_q.hi[0]); // R8

    AST_HI_UNTOUCHED: assert property (@(posedge clk) disable iff (rst)
        (job_vld && job.sat && !ovf) |=> $stable(acc_q.hi)); // R6

    AST_ACC_IDLE: assert property (@(posedge clk) disable iff (rst)
        (!job_vld && !ld) |=> $stable(acc_q)); // R10

endmodule

// File: rtl/smac_unit.sv
module smac_unit
    import smac_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int PTR_STEP = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              sat_mode,
    input  logic              ptr_ld,
    input  logic [ADDR_W-1:0] ptr_a_in,
    input  logic [ADDR_W-1:0] ptr_b_in,
    input  logic              acc_ld,
    input  logic [31:0]       acc_hi_in,
    input  logic [31:0]       acc_lo_in,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_ack,
    input  logic [15:0]       rd_data,
    output logic [ADDR_W-1:0] ptr_a,
    output logic [ADDR_W-1:0] ptr_b,
    output logic [31:0]       acc_hi,
    output logic [31:0]       acc_lo,
    output logic              busy,
    output logic              done
);

    logic job_vld;
    job_t job;
    acc_t acc;
    acc_t ld_val;
    logic acc_ld_go;
    logic done_q;

    assign ld_val    = '{hi: acc_hi_in, lo: acc_lo_in};
    assign acc_ld_go = acc_ld && !busy;

    smac_fetch #(
        .ADDR_W   (ADDR_W),
        .PTR_STEP (PTR_STEP)
    ) u_fetch (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .sat_mode (sat_mode),
        .ptr_ld   (ptr_ld),
        .ptr_a_in (ptr_a_in),
        .ptr_b_in (ptr_b_in),
        .rd_req   (rd_req),
        .rd_addr  (rd_addr),
        .rd_ack   (rd_ack),
        .rd_data  (rd_data),
        .ptr_a    (ptr_a),
        .ptr_b    (ptr_b),
        .busy     (busy),
        .job_vld  (job_vld),
        .job      (job)
    );

    smac_acc u_acc (
        .clk     (clk),
        .rst     (rst),
        .job_vld (job_vld),
        .job     (job),
        .ld      (acc_ld_go),
        .ld_val  (ld_val),
        .acc     (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
        end else begin
            done_q <= job_vld;
        end
    end

    assign done   = done_q;
    assign acc_hi = acc.hi;
    assign acc_lo = acc.lo;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R9

    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R9

    AST_REQ_BUSY: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> busy); // R2

endmodule

// File: tb/smac_unit_test.sv
`timescale 1ns/1ps
module smac_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        sat_mode = 1'b0;
    logic        ptr_ld = 1'b0;
    logic [31:0] ptr_a_in = '0;
    logic [31:0] ptr_b_in = '0;
    logic        acc_ld = 1'b0;
    logic [31:0] acc_hi_in = '0;
    logic [31:0] acc_lo_in = '0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_ack;
    logic [15:0] rd_data;
    logic [31:0] ptr_a;
    logic [31:0] ptr_b;
    logic [31:0] acc_hi;
    logic [31:0] acc_lo;
    logic        busy;
    logic        done;

    int total = 0;
    int bad = 0;
    int lat = 0;
    int ack_cnt = 0;
    int req_total = 0;
    logic [31:0] log_prev = '0;
    logic [31:0] log_last = '0;
    logic [15:0] mem [0:63];
    logic [63:0] exp_acc = '0;
    logic [31:0] exp_pa = '0;
    logic [31:0] exp_pb = '0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    smac_unit uut (
        .clk(clk), .rst(rst), .start(start), .sat_mode(sat_mode),
        .ptr_ld(ptr_ld), .ptr_a_in(ptr_a_in), .ptr_b_in(ptr_b_in),
        .acc_ld(acc_ld), .acc_hi_in(acc_hi_in), .acc_lo_in(acc_lo_in),
        .rd_req(rd_req), .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data),
        .ptr_a(ptr_a), .ptr_b(ptr_b), .acc_hi(acc_hi), .acc_lo(acc_lo),
        .busy(busy), .done(done)
    );

    // memory responder with programmable latency
    always @(posedge clk) begin
        if (rst) begin
            rd_ack  <= 1'b0;
            rd_data <= '0;
            ack_cnt <= 0;
        end else if (rd_ack) begin
            rd_ack  <= 1'b0;
            ack_cnt <= 0;
        end else if (rd_req) begin
            if (ack_cnt >= lat) begin
                rd_ack  <= 1'b1;
                rd_data <= mem[rd_addr[6:1]];
            end else begin
                ack_cnt <= ack_cnt + 1;
            end
        end
    end

    always @(negedge clk) begin
        if (!rst && rd_req && rd_ack) begin
            log_prev  <= log_last;
            log_last  <= rd_addr;
            req_total <= req_total + 1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] val_of(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h0001;
            2: return 16'hFFFF;
            3: return 16'h7FFF;
            4: return 16'h8000;
            5: return 16'h0100;
            6: return 16'hFF00;
            default: return 16'h1234;
        endcase
    endfunction

    function automatic logic [31:0] lo_of(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h7FFF_0000;
            2: return 32'h8000_8000;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // reference step, written from the requirements
    function automatic logic [63:0] model(input logic [63:0] acc, input logic [15:0] a,
                                          input logic [15:0] b, input logic sat);
        longint pa;
        longint pb;
        longint prod;
        longint lo_s;
        longint sum;
        logic [31:0] hi;
        pa = longint'($signed(a));
        pb = longint'($signed(b));
        prod = pa * pb;
        if (!sat)
            return acc + 64'(prod);
        hi = acc[63:32];
        lo_s = longint'($signed(acc[31:0]));
        sum = lo_s + prod;
        if (sum > 64'sd2147483647)
            return {hi | 32'd1, 32'h7FFF_FFFF};
        if (sum < -64'sd2147483648)
            return {hi | 32'd1, 32'h8000_0000};
        return {hi, sum[31:0]};
    endfunction

    task automatic load(input logic [31:0] pa, input logic [31:0] pb,
                        input logic [31:0] hi, input logic [31:0] lo);
        @(negedge clk);
        ptr_ld = 1'b1; ptr_a_in = pa; ptr_b_in = pb;
        acc_ld = 1'b1; acc_hi_in = hi; acc_lo_in = lo;
        @(negedge clk);
        ptr_ld = 1'b0; acc_ld = 1'b0;
        exp_pa = pa; exp_pb = pb; exp_acc = {hi, lo};
    endtask

    task automatic run_op(input bit poke, input string tag);
        int n;
        int base;
        logic [31:0] old_pa;
        logic [31:0] old_pb;
        logic mode;
        old_pa = exp_pa;
        old_pb = exp_pb;
        mode = sat_mode;
        exp_acc = model(exp_acc, mem[old_pa[6:1]], mem[old_pb[6:1]], mode);
        exp_pa = old_pa + 32'd2;
        exp_pb = old_pb + 32'd2;
        base = req_total;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke) begin
            chk("R9 busy", {63'd0, busy}, 64'd1);
            ptr_ld = 1'b1; ptr_a_in = 32'h0000_0040; ptr_b_in = 32'h0000_0044;
            acc_ld = 1'b1; acc_hi_in = 32'h5A5A_5A5A; acc_lo_in = 32'hA5A5_A5A5;
            start = 1'b1; sat_mode = ~mode;
            @(negedge clk);
            ptr_ld = 1'b0; acc_ld = 1'b0; start = 1'b0; sat_mode = mode;
        end
        n = 0;
        while (!done && n < 200) begin
            @(negedge clk);
            n++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL R9 %s actual=no-done expected=done", tag);
        end
        chk({"R9 busy-at-done ", tag}, {63'd0, busy}, 64'd0);
        if (mode) chk({"R6 R7 R8 acc ", tag}, {acc_hi, acc_lo}, exp_acc);
        else      chk({"R4 R5 acc ", tag}, {acc_hi, acc_lo}, exp_acc);
        chk({"R3 ptr_a ", tag}, {32'd0, ptr_a}, {32'd0, exp_pa});
        chk({"R3 ptr_b ", tag}, {32'd0, ptr_b}, {32'd0, exp_pb});
        chk({"R2 reads ", tag}, 64'(req_total - base), 64'd2);
        chk({"R2 order ", tag}, {log_prev, log_last}, {old_pa, old_pb});
        @(negedge clk);
        chk({"R9 pulse ", tag}, {63'd0, done}, 64'd0);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;
        for (int i = 0; i < 8; i++) begin
            mem[i]      = val_of(i);
            mem[32 + i] = val_of(i);
        end
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1 acc", {acc_hi, acc_lo}, 64'd0);
        chk("R1 ptrs", {ptr_a, ptr_b}, 64'd0);
        chk("R1 ctl", {61'd0, busy, done, rd_req}, 64'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after release", {acc_hi, acc_lo}, 64'd0);

        // sweep: mode x operand pairs x lower-word presets
        for (int m = 0; m < 2; m++) begin
            sat_mode = m[0];
            for (int k = 0; k < 4; k++) begin
                for (int ia = 0; ia < 8; ia++) begin
                    for (int ib = 0; ib < 8; ib++) begin
                        lat = (ia + ib + k) % 3;
                        load(32'hA000_0000 | 32'(ia * 2), 32'h0000_0040 | 32'(ib * 2),
                             32'h0000_0100 | 32'(k), lo_of(k));
                        run_op(1'b0, "sweep");
                    end
                end
            end
        end

        // R8: sticky bit survives a later non-overflowing step, load clears it
        sat_mode = 1'b1;
        lat = 0;
        load(32'h0000_0002, 32'h0000_0042, 32'h0000_0000, 32'h7FFF_FFFF);
        run_op(1'b0, "sticky-set");
        chk("R8 sticky set", {32'd0, acc_hi}, 64'd1);
        mem[2] = 16'h0000;
        load(32'h0000_0004, 32'h0000_0042, 32'h0000_0001, 32'h0000_0010);
        run_op(1'b0, "sticky-hold");
        chk("R8 sticky hold", {32'd0, acc_hi}, 64'd1);
        load(32'h0000_0004, 32'h0000_0042, 32'h0000_0000, 32'h0000_0000);
        chk("R8 cleared by load", {32'd0, acc_hi}, 64'd0);
        mem[2] = val_of(2);

        // R3: pointer wrap at the top of the address space
        sat_mode = 1'b0;
        mem[63] = 16'h0003;
        load(32'hFFFF_FFFE, 32'h0000_0046, 32'h0000_0000, 32'h0000_0005);
        run_op(1'b0, "wrap");
        chk("R3 wrap", {32'd0, ptr_a}, 64'd0);
        mem[63] = 16'h0000;

        // R10: inputs pulsed while busy, mode flipped mid-step
        for (int m = 0; m < 2; m++) begin
            sat_mode = m[0];
            lat = 1;
            load(32'h0000_0006, 32'h0000_0046, 32'h0000_0000, 32'h7FFF_0000);
            run_op(1'b1, "busy-ignore");
        end

        // chained steps without reload, both pointers equal
        sat_mode = 1'b0;
        lat = 2;
        load(32'h0000_0008, 32'h0000_0008, 32'hFFFF_FFFF, 32'hFFFF_FFF0);
        for (int s = 0; s < 4; s++) run_op(1'b0, "chain");

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule